// File: doc/BRIEF.md
# Parallel NOR Flash Reset Sequencer

This block sits on the host side of a parallel NOR flash device. It drives the device's active-low reset pin and watches the device's ready/busy pin. It produces a safe reset pulse at power-up and whenever software asks for one. A read-gate flag tells the rest of the host when the device can again return valid data. Every delay is a whole number of clock cycles. Each count is derived from a nanosecond parameter and the clock period, and is rounded up.

The ready/busy pin passes through a two-stage synchroniser before the controller uses it. On a reset request the controller first records two things: whether the host's busy-status flag showed a program, erase or lock-bit operation in progress, and which supply range is selected.

- **Idle case:** the reset pin is held low only for the minimum pulse.
- **Busy case:** the reset pin is held low for the worst-case abort time of the selected supply range.

After release, the controller waits for the later of two events: the release itself, and the synchronised ready/busy pin reading high. It then waits a further output-valid delay before it raises the read-gate flag. If ready/busy stays low too long, a sticky timeout error is raised. The read gate then stays closed until the next reset request.

States and transitions:
- POWER_WAIT → RELEASE after the supply has been good for the full pulse time.
- READY → ASSERT on a request.
- ASSERT → HOLD_BUSY if an operation was running, otherwise ASSERT → RELEASE.
- HOLD_BUSY → RELEASE once the abort window has expired.
- RELEASE → OUTPUT_WAIT when ready/busy is seen high.
- RELEASE → READY with the error set on a timeout.
- OUTPUT_WAIT → READY when the output-valid delay has elapsed.

Top module: `nor_rst_seq`

## Requirements
- R1: While `rst_n` is low, `flash_rst_n`, `rd_ready` and `timeout_err` are all 0.
- R2: After `rst_n` is released, `flash_rst_n` stays 0 until `supply_ok` has been 1 for 10 consecutive cycles (the 100 ns pulse at 10 ns). Any cycle with `supply_ok` at 0 restarts the count. `flash_rst_n` rises exactly 10 cycles after `supply_ok` is driven high for good.
- R3: A `reset_req` sampled while `rd_ready` is 1, or while the block is ready but blocked by a timeout, takes effect on the next cycle: `flash_rst_n` and `rd_ready` both read 0, and `timeout_err` is cleared.
- R4: `reset_req` is ignored in every state other than ready. No extra reset pulse occurs and the timing of the sequence in progress is unchanged.
- R5: With `op_busy` at 0 when the request is taken, `flash_rst_n` is low for exactly 10 cycles.
- R6: With `op_busy` at 1 when the request is taken, `flash_rst_n` is low for the abort window selected by `vsel`: code 0 (2.7 V) gives 2800 cycles, code 1 (3.0–3.6 V) gives 2000, code 2 (5 V) gives 1200, and code 3 is treated as 2.7 V (2800).
- R7: `rd_ready` rises a fixed time after the later of two events. If `rdy_pin` is already high when `flash_rst_n` rises, `rd_ready` rises 16 cycles after `flash_rst_n`. If `rdy_pin` rises later, `rd_ready` rises 18 cycles after the pin: 2 synchroniser stages, 1 decision cycle and a 15-cycle output-valid delay.
- R8: A timeout limit is counted from the fall of `flash_rst_n`: 210 cycles when idle, or the abort window plus 200 when busy. If synchronised ready/busy is not high when the limit is reached, `timeout_err` rises and `rd_ready` stays 0 even after `rdy_pin` later goes high. Ready/busy seen high in the limit cycle itself takes precedence over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| supply_ok | input | 1 | Supply in range and settled |
| reset_req | input | 1 | Request for a device reset |
| op_busy | input | 1 | Device is running a program, erase or lock-bit operation |
| vsel | input | 2 | Supply range: 0 = 2.7 V, 1 = 3.0–3.6 V, 2 = 5 V, 3 = as 0 |
| rdy_pin | input | 1 | Device ready/busy pin, high = ready (asynchronous) |
| flash_rst_n | output | 1 | Active-low reset pin of the device |
| rd_ready | output | 1 | Device may be read |
| timeout_err | output | 1 | Sticky ready/busy timeout |

## Verification
Two functions can fall in the same cycle: the ready/busy pin being seen high, and the timeout limit being reached. Both can occur at the very clock edge where the controller sits in RELEASE. The bench provokes this with an idle reset whose pin rise is placed so that its synchronised value arrives exactly at the limit edge; this run must reach ready with no error. A second run moves the pin rise one cycle later and must raise the timeout. Every edge on the three outputs is compared against a scoreboard queue of expected (signal, value, cycle) items.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    typedef enum logic [2:0] {
        ST_POWER_WAIT,
        ST_ASSERT,
        ST_HOLD_BUSY,
        ST_RELEASE,
        ST_OUTPUT_WAIT,
        ST_READY
    } nrs_state_e;

    localparam logic [1:0] VS_LOW27 = 2'd0;
    localparam logic [1:0] VS_MID33 = 2'd1;
    localparam logic [1:0] VS_HIGH5 = 2'd2;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nrs_sync.sv
module nrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nrs_window.sv
module nrs_window #(
    parameter int CW         = 13,
    parameter int PULSE_CYC  = 10,
    parameter int A27_CYC    = 2800,
    parameter int A33_CYC    = 2000,
    parameter int A50_CYC    = 1200,
    parameter int MARGIN_CYC = 200
) (
    input  logic [1:0]    vsel_q,
    input  logic          busy_q,
    output logic [CW-1:0] abort_cyc,
    output logic [CW-1:0] limit_cyc
);
    import nrs_pkg::*;

    always_comb begin
        unique case (vsel_q)
            VS_MID33: abort_cyc = CW'(A33_CYC);
            VS_HIGH5: abort_cyc = CW'(A50_CYC);
            default:  abort_cyc = CW'(A27_CYC);
        endcase
        limit_cyc = busy_q ? (abort_cyc + CW'(MARGIN_CYC))
                           : CW'(PULSE_CYC + MARGIN_CYC);
    end
endmodule

// File: rtl/nrs_fsm.sv
module nrs_fsm #(
    parameter int CW        = 13,
    parameter int PULSE_CYC = 10,
    parameter int OV_CYC    = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          reset_req,
    input  logic          op_busy,
    input  logic [1:0]    vsel,
    input  logic          ryby_s,
    input  logic [CW-1:0] abort_cyc,
    input  logic [CW-1:0] limit_cyc,
    output logic          busy_q,
    output logic [1:0]    vsel_q,
    output logic          flash_rst_n,
    output logic          rd_ready,
    output logic          timeout_err
);
    import nrs_pkg::*;

    nrs_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] el;
    logic          take_req;
    logic          tmo_hit;

    assign take_req = (state == ST_READY) && reset_req;
    assign tmo_hit  = (state == ST_RELEASE) && !ryby_s && (el >= limit_cyc - CW'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_POWER_WAIT:  if (supply_ok && cnt == CW'(PULSE_CYC - 1)) nxt = ST_RELEASE;
            ST_READY:       if (reset_req) nxt = ST_ASSERT;
            ST_ASSERT:      if (el == CW'(PULSE_CYC - 1))
                                nxt = busy_q ? ST_HOLD_BUSY : ST_RELEASE;
            ST_HOLD_BUSY:   if (el == abort_cyc - CW'(1)) nxt = ST_RELEASE;
            ST_RELEASE:     if (ryby_s) nxt = ST_OUTPUT_WAIT;
                            else if (tmo_hit) nxt = ST_READY;
            ST_OUTPUT_WAIT: if (cnt == CW'(OV_CYC - 1)) nxt = ST_READY;
            default:        nxt = ST_POWER_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_POWER_WAIT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            el          <= '0;
            busy_q      <= 1'b0;
            vsel_q      <= VS_LOW27;
            timeout_err <= 1'b0;
        end else begin
            if (state != nxt)
                cnt <= '0;
            else if (state == ST_OUTPUT_WAIT || (state == ST_POWER_WAIT && supply_ok))
                cnt <= cnt + CW'(1);
            else
                cnt <= '0;

            if (take_req || state == ST_POWER_WAIT)
                el <= '0;
            else if (state inside {ST_ASSERT, ST_HOLD_BUSY, ST_RELEASE})
                el <= el + CW'(1);

            if (take_req) begin
                busy_q      <= op_busy;
                vsel_q      <= vsel;
                timeout_err <= 1'b0;
            end else if (tmo_hit) begin
                timeout_err <= 1'b1;
            end
        end
    end

    always_comb begin
        flash_rst_n = !(state inside {ST_POWER_WAIT, ST_ASSERT, ST_HOLD_BUSY});
        rd_ready    = (state == ST_READY) && !timeout_err;
    end

    // Checker-only counter: length of the current low phase of the reset pin.
    logic [CW-1:0] low_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 low_len <= '0;
        else if (flash_rst_n)       low_len <= '0;
        else if (low_len != '1)     low_len <= low_len + CW'(1);
    end

    // R2
    pw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POWER_WAIT && !supply_ok) |=> !flash_rst_n);

    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && reset_req) |=> (!flash_rst_n && !rd_ready));

    // R4
    req_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && state inside {ST_HOLD_BUSY, ST_RELEASE, ST_OUTPUT_WAIT})
        |=> (state != ST_ASSERT));

    // R5
    min_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_rst_n) |-> (low_len >= CW'(PULSE_CYC)));

    // R7
    rd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ready) |-> (flash_rst_n && $past(flash_rst_n)));

    // R8
    tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (flash_rst_n && !$past(ryby_s) && !rd_ready));
endmodule

// File: rtl/nor_rst_seq.sv
module nor_rst_seq #(
    parameter int CLK_NS      = 10,
    parameter int PULSE_NS    = 100,
    parameter int ABORT27_NS  = 28000,
    parameter int ABORT33_NS  = 20000,
    parameter int ABORT50_NS  = 12000,
    parameter int OUTVALID_NS = 150,
    parameter int MARGIN_NS   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       reset_req,
    input  logic       op_busy,
    input  logic [1:0] vsel,
    input  logic       rdy_pin,
    output logic       flash_rst_n,
    output logic       rd_ready,
    output logic       timeout_err
);
    import nrs_pkg::*;

    localparam int PULSE_CYC  = ns_to_cyc(PULSE_NS, CLK_NS);
    localparam int A27_CYC    = ns_to_cyc(ABORT27_NS, CLK_NS);
    localparam int A33_CYC    = ns_to_cyc(ABORT33_NS, CLK_NS);
    localparam int A50_CYC    = ns_to_cyc(ABORT50_NS, CLK_NS);
    localparam int OV_CYC     = ns_to_cyc(OUTVALID_NS, CLK_NS);
    localparam int MARGIN_CYC = ns_to_cyc(MARGIN_NS, CLK_NS);
    localparam int MAX_WIN    = max3(A27_CYC, A33_CYC, A50_CYC) + MARGIN_CYC + PULSE_CYC + OV_CYC;
    localparam int CW         = $clog2(MAX_WIN + 2) + 1;

    logic          ryby_s;
    logic          busy_q;
    logic [1:0]    vsel_q;
    logic [CW-1:0] abort_cyc;
    logic [CW-1:0] limit_cyc;

    nrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rdy_pin),
        .q     (ryby_s)
    );

    nrs_window #(
        .CW         (CW),
        .PULSE_CYC  (PULSE_CYC),
        .A27_CYC    (A27_CYC),
        .A33_CYC    (A33_CYC),
        .A50_CYC    (A50_CYC),
        .MARGIN_CYC (MARGIN_CYC)
    ) u_window (
        .vsel_q    (vsel_q),
        .busy_q    (busy_q),
        .abort_cyc (abort_cyc),
        .limit_cyc (limit_cyc)
    );

    nrs_fsm #(
        .CW        (CW),
        .PULSE_CYC (PULSE_CYC),
        .OV_CYC    (OV_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .reset_req   (reset_req),
        .op_busy     (op_busy),
        .vsel        (vsel),
        .ryby_s      (ryby_s),
        .abort_cyc   (abort_cyc),
        .limit_cyc   (limit_cyc),
        .busy_q      (busy_q),
        .vsel_q      (vsel_q),
        .flash_rst_n (flash_rst_n),
        .rd_ready    (rd_ready),
        .timeout_err (timeout_err)
    );
endmodule

// File: tb/tb_nor_rst_seq.sv
module tb_nor_rst_seq;

    localparam int K_RP = 0;
    localparam int K_RD = 1;
    localparam int K_TO = 2;

    typedef struct {
        int    kind;
        bit    val;
        int    cyc;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       reset_req = 1'b0;
    logic       op_busy = 1'b0;
    logic [1:0] vsel = 2'd0;
    logic       rdy_pin = 1'b1;
    logic       flash_rst_n, rd_ready, timeout_err;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nor_rst_seq dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .reset_req(reset_req),
        .op_busy(op_busy), .vsel(vsel), .rdy_pin(rdy_pin),
        .flash_rst_n(flash_rst_n), .rd_ready(rd_ready), .timeout_err(timeout_err)
    );

    function automatic string kname(input int k);
        return (k == K_RP) ? "flash_rst_n" : (k == K_RD) ? "rd_ready" : "timeout_err";
    endfunction

    task automatic push(input int k, input bit v, input int c, input string r);
        exp_t e;
        e.kind = k; e.val = v; e.cyc = c; e.req = r;
        sb.push_back(e);
    endtask

    task automatic direct(input bit ok, input string r, input string what,
                          input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, expv);
        end
    endtask

    task automatic observe(input int k, input bit v);
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
            fails++;
            $display("FAIL R4 unexpected %s->%0d at cycle %0d actual=event expected=none",
                     kname(k), v, cyc);
        end else begin
            e = sb.pop_front();
            if (e.kind != k || e.val != v || e.cyc != cyc) begin
                fails++;
                $display("FAIL %s actual=%s->%0d@%0d expected=%s->%0d@%0d",
                         e.req, kname(k), v, cyc, kname(e.kind), e.val, e.cyc);
            end
        end
    endtask

    // Monitor: every output edge pops one expected item.
    initial begin
        bit p_rp, p_rd, p_to;
        p_rp = 1'b0; p_rd = 1'b0; p_to = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (flash_rst_n !== p_rp) begin observe(K_RP, flash_rst_n); p_rp = flash_rst_n; end
                if (rd_ready    !== p_rd) begin observe(K_RD, rd_ready);    p_rd = rd_ready;    end
                if (timeout_err !== p_to) begin observe(K_TO, timeout_err); p_to = timeout_err; end
            end
        end
    end

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic issue(input bit busy, input logic [1:0] vs, input bit rd_was,
                         input bit to_was, output int n);
        op_busy   = busy;
        vsel      = vs;
        reset_req = 1'b1;
        n = cyc;
        push(K_RP, 1'b0, n + 1, "R3");
        if (rd_was) push(K_RD, 1'b0, n + 1, "R3");
        if (to_was) push(K_TO, 1'b0, n + 1, "R3");
        @(negedge clk);
        reset_req = 1'b0;
        op_busy   = 1'b0;
    endtask

    task automatic pulse_req(input int c);
        wait_to(c);
        reset_req = 1'b1;
        @(negedge clk);
        reset_req = 1'b0;
    endtask

    task automatic busy_run(input logic [1:0] vs, input int win, input bit late);
        int n;
        rdy_pin = 1'b0;
        @(negedge clk);
        issue(1'b1, vs, 1'b1, 1'b0, n);
        push(K_RP, 1'b1, n + 1 + win, "R6");
        if (!late) begin
            push(K_RD, 1'b1, n + 1 + win + 16, "R7");
            wait_to(n + win - 5);
        end else begin
            push(K_RD, 1'b1, n + win + 20 + 18, "R7");
            wait_to(n + win + 20);
        end
        rdy_pin = 1'b1;
        drain();
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        direct(flash_rst_n == 1'b0, "R1", "flash_rst_n in reset", flash_rst_n, 0);
        direct(rd_ready == 1'b0,    "R1", "rd_ready in reset",    rd_ready, 0);
        direct(timeout_err == 1'b0, "R1", "timeout_err in reset", timeout_err, 0);
        rst_n  = 1'b1;
        mon_on = 1'b1;

        // R2: power-up with an interrupted supply-good interval
        repeat (5) @(negedge clk);
        direct(flash_rst_n == 1'b0, "R2", "pin before supply good", flash_rst_n, 0);
        supply_ok = 1'b1;
        repeat (6) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        n = cyc;
        push(K_RP, 1'b1, n + 10, "R2");
        push(K_RD, 1'b1, n + 26, "R7");
        drain();

        // R5 R7: idle reset with stray requests (R4)
        issue(1'b0, 2'd0, 1'b1, 1'b0, n);
        push(K_RP, 1'b1, n + 11, "R5");
        push(K_RD, 1'b1, n + 27, "R7");
        pulse_req(n + 3);
        pulse_req(n + 11);
        pulse_req(n + 16);
        drain();

        // R6: each supply range, R7 both orderings
        busy_run(2'd0, 2800, 1'b0);
        busy_run(2'd1, 2000, 1'b0);
        busy_run(2'd2, 1200, 1'b1);
        busy_run(2'd3, 2800, 1'b0);

        // R8: idle timeout, then late pin keeps the gate closed
        rdy_pin = 1'b0;
        @(negedge clk);
        issue(1'b0, 2'd1, 1'b1, 1'b0, n);
        push(K_RP, 1'b1, n + 11, "R5");
        push(K_TO, 1'b1, n + 211, "R8");
        drain();
        rdy_pin = 1'b1;
        repeat (30) @(negedge clk);
        direct(rd_ready == 1'b0, "R8", "rd_ready after timeout", rd_ready, 0);
        direct(timeout_err == 1'b1, "R8", "error is sticky", timeout_err, 1);
        issue(1'b0, 2'd1, 1'b0, 1'b1, n);
        push(K_RP, 1'b1, n + 11, "R5");
        push(K_RD, 1'b1, n + 27, "R7");
        drain();

        // R8: pin seen in the limit cycle wins
        rdy_pin = 1'b0;
        @(negedge clk);
        issue(1'b0, 2'd2, 1'b1, 1'b0, n);
        push(K_RP, 1'b1, n + 11, "R5");
        push(K_RD, 1'b1, n + 226, "R8");
        wait_to(n + 208);
        rdy_pin = 1'b1;
        drain();

        // R8: one cycle later the timeout wins
        rdy_pin = 1'b0;
        @(negedge clk);
        issue(1'b0, 2'd2, 1'b1, 1'b0, n);
        push(K_RP, 1'b1, n + 11, "R5");
        push(K_TO, 1'b1, n + 211, "R8");
        wait_to(n + 209);
        rdy_pin = 1'b1;
        drain();
        issue(1'b0, 2'd2, 1'b0, 1'b1, n);
        push(K_RP, 1'b1, n + 11, "R5");
        push(K_RD, 1'b1, n + 27, "R7");
        drain();

        while (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            fails++;
            $display("FAIL %s actual=missing expected=%s->%0d@%0d", e.req, kname(e.kind), e.val, e.cyc);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule